// File: doc/BRIEF.md
# SD Command Issue Engine

This block is the command half of an SD host controller. Software loads a 32-bit argument, then writes a 16-bit command word. That word holds the command index and the flags for response length, no-response, wait-for-busy and data direction. Setting the start bit launches the command. The engine sends a one-cycle request carrying the index and the argument to a card-side port. It then waits for the card's response and stores it in four 32-bit response registers.

When the command ends, hardware clears the start bit. If the command ended in error, hardware also sets a fail bit in the same word. Three write-one-to-clear status bits record what happened: command timeout, CRC7 error and busy completion. A fourth records an attempt to write the command word while a command was still pending. The cycle limit for the response wait is programmable. Serialization of the CMD line, the CRC7 calculation and data transfer are done elsewhere. On the card-side port, the card reports a response together with a CRC verdict, then holds a busy level for as long as it needs.

Top module: `sd_cmd_engine`

## Requirements
- R1: While reset is asserted, and on the first register read after reset, these registers read zero: the command word (0x00), the argument (0x04), the four response words (0x10, 0x14, 0x18, 0x1c) and the status register (0x20).
- R2: The command word layout is: bits 5:0 index, bit 6 read-data, bit 7 write-data, bit 9 long response, bit 10 no response, bit 11 wait-for-busy, bit 14 fail, bit 15 start/pending. Writing it with bit 15 set launches exactly one request on `card_cmd_valid`, one cycle wide. That request carries bits 5:0, the argument register and bit 9. Writing it with bit 15 clear stores the word and launches nothing.
- R3: A response with bit 9 clear stores `card_rsp_data[31:0]` in the word at 0x10 and zeroes the words at 0x14 to 0x1c. A response with bit 9 set stores bits 31:0, 63:32, 95:64 and 127:96 at 0x10, 0x14, 0x18 and 0x1c respectively.
- R4: Hardware clears bit 15 when a command finishes. A command with bit 10 set finishes right after its request, does not wait for a response and leaves the response words unchanged.
- R5: If no response arrives within the number of cycles held in the limit register (0x08, reset value 64), the engine sets status bit 6 and command bit 14, clears bit 15 and leaves the response words unchanged. A response in cycle k of the wait, counted from 0, is accepted if and only if k is at most the limit. A response that arrives while no command is waiting is ignored.
- R6: A response marked with `card_rsp_crc_err` sets status bit 4 and command bit 14 and ends the command without any busy wait.
- R7: With bit 11 set, completion is held off until `card_busy` is low after the response, and then status bit 10 is set. With bit 11 clear, status bit 10 stays clear and `card_busy` is ignored.
- R8: A command word with both bit 9 and bit 11 set, launched with bit 15, issues no request. It finishes at once with bit 14 set and no status bit set.
- R9: A write to the command word while bit 15 is set is ignored: bits 13:0 keep their value. Status bit 1 records the attempt.
- R10: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| card_cmd_valid | output | 1 | One-cycle command request to the card side |
| card_cmd_index | output | 6 | Command index of the request |
| card_cmd_arg | output | 32 | Command argument of the request |
| card_cmd_long | output | 1 | Request expects a 136-bit response |
| card_rsp_valid | input | 1 | Response present this cycle |
| card_rsp_data | input | 128 | Response payload, CRC stripped |
| card_rsp_crc_err | input | 1 | Response failed its CRC7 check |
| card_busy | input | 1 | Card signals busy |

## Verification
The assertions check the following on every cycle:
- each request is one cycle wide;
- a request appears only while a command is pending, and never for the long-with-busy combination;
- an ignored write leaves the index and flags intact and sets the collision bit;
- a rising timeout bit coincides with a set fail bit and a cleared start bit;
- busy completion follows a low `card_busy` on a busy-wait command;
- reset zeroes the registers.

The response word layout, the exact timeout boundary, the preserved response words after timeouts and no-response commands, and the write-one-to-clear behaviour are shown only by the bench's scenarios. Those scenarios compare the register readback with a model of each command's outcome.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

    localparam int REG_AW     = 8;
    localparam int DATA_W     = 32;
    localparam int RSP_WORDS  = 4;
    localparam int STS_W      = 11;

    localparam logic [REG_AW-1:0] OFS_CMD  = 8'h00;
    localparam logic [REG_AW-1:0] OFS_ARG  = 8'h04;
    localparam logic [REG_AW-1:0] OFS_TMO  = 8'h08;
    localparam logic [REG_AW-1:0] OFS_RSP0 = 8'h10;
    localparam logic [REG_AW-1:0] OFS_STS  = 8'h20;

    // command word bit positions
    localparam int CB_START = 15;
    localparam int CB_FAIL  = 14;
    localparam int CB_BUSY  = 11;
    localparam int CB_NORSP = 10;
    localparam int CB_LONG  = 9;

    // status bit positions
    localparam int SB_COLL = 1;
    localparam int SB_CRC  = 4;
    localparam int SB_TMO  = 6;
    localparam int SB_BUSY = 10;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT_RSP,
        ST_WAIT_BUSY
    } seq_state_t;

    typedef struct packed {
        logic done;
        logic fail;
        logic tmo;
        logic crc;
        logic busy_done;
    } seq_evt_t;

    function automatic logic bad_combo(input logic [15:0] w);
        return w[CB_LONG] && w[CB_BUSY];
    endfunction

endpackage

// File: rtl/sd_cmd_seq.sv
module sd_cmd_seq
    import sd_cmd_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pending,
    input  logic             combo_bad,
    input  logic             no_rsp,
    input  logic             busy_wait,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic             rsp_valid,
    input  logic             rsp_crc_err,
    input  logic             card_busy,
    output logic             req_valid,
    output logic             rsp_capture,
    output seq_evt_t         evt
);

    seq_state_t       state_q, state_d;
    logic [TMO_W-1:0] cnt_q;

    always_comb begin
        state_d     = state_q;
        evt         = '0;
        req_valid   = 1'b0;
        rsp_capture = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pending) begin
                    if (combo_bad) begin
                        evt.done = 1'b1;
                        evt.fail = 1'b1;
                    end else begin
                        state_d = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                req_valid = 1'b1;
                if (no_rsp) begin
                    evt.done = 1'b1;
                    state_d  = ST_IDLE;
                end else begin
                    state_d  = ST_WAIT_RSP;
                end
            end
            ST_WAIT_RSP: begin
                if (rsp_valid) begin
                    rsp_capture = 1'b1;
                    if (rsp_crc_err) begin
                        evt.done = 1'b1;
                        evt.fail = 1'b1;
                        evt.crc  = 1'b1;
                        state_d  = ST_IDLE;
                    end else if (busy_wait) begin
                        state_d  = ST_WAIT_BUSY;
                    end else begin
                        evt.done = 1'b1;
                        state_d  = ST_IDLE;
                    end
                end else if (cnt_q >= tmo_limit) begin
                    evt.done = 1'b1;
                    evt.fail = 1'b1;
                    evt.tmo  = 1'b1;
                    state_d  = ST_IDLE;
                end
            end
            ST_WAIT_BUSY: begin
                if (!card_busy) begin
                    evt.done      = 1'b1;
                    evt.busy_done = 1'b1;
                    state_d       = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_WAIT_RSP && state_d == ST_WAIT_RSP)
                cnt_q <= cnt_q + 1'b1;
            else
                cnt_q <= '0;
        end
    end

endmodule

// File: rtl/sd_cmd_rspbank.sv
module sd_cmd_rspbank #(
    parameter int WORDS  = 4,
    parameter int WORD_W = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           capture,
    input  logic                           long_rsp,
    input  logic [WORDS*WORD_W-1:0]        rsp_data,
    output logic [WORDS-1:0][WORD_W-1:0]   rsp_q
);

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                rsp_q[g] <= '0;
            else if (capture) begin
                if (long_rsp || g == 0)
                    rsp_q[g] <= rsp_data[g*WORD_W +: WORD_W];
                else
                    rsp_q[g] <= '0;
            end
        end
    end

endmodule

// File: rtl/sd_cmd_status.sv
module sd_cmd_status #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_bits,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] sts_q
);

    always_ff @(posedge clk) begin
        if (rst)
            sts_q <= '0;
        else
            sts_q <= (sts_q & ~clr_bits) | set_bits;
    end

endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
    import sd_cmd_pkg::*;
#(
    parameter int              TMO_W     = 16,
    parameter logic [TMO_W-1:0] TMO_RESET = 16'd64
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      reg_wr,
    input  logic [REG_AW-1:0]         reg_addr,
    input  logic [DATA_W-1:0]         reg_wdata,
    output logic [DATA_W-1:0]         reg_rdata,
    output logic                      card_cmd_valid,
    output logic [5:0]                card_cmd_index,
    output logic [DATA_W-1:0]         card_cmd_arg,
    output logic                      card_cmd_long,
    input  logic                      card_rsp_valid,
    input  logic [RSP_WORDS*DATA_W-1:0] card_rsp_data,
    input  logic                      card_rsp_crc_err,
    input  logic                      card_busy
);

    logic [15:0]        cmd_q;
    logic [DATA_W-1:0]  arg_q;
    logic [TMO_W-1:0]   tmo_q;
    logic [STS_W-1:0]   sts_q, sts_set, sts_clr;
    logic [RSP_WORDS-1:0][DATA_W-1:0] rsp_q;
    logic               rsp_capture;
    logic               wr_cmd, collide;
    seq_evt_t           evt;

    assign wr_cmd  = reg_wr && (reg_addr == OFS_CMD);
    assign collide = wr_cmd && cmd_q[CB_START];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            arg_q <= '0;
            tmo_q <= TMO_RESET;
        end else begin
            if (wr_cmd && !cmd_q[CB_START]) begin
                cmd_q           <= reg_wdata[15:0];
                cmd_q[CB_FAIL]  <= 1'b0;
            end else if (evt.done) begin
                cmd_q[CB_START] <= 1'b0;
                if (evt.fail)
                    cmd_q[CB_FAIL] <= 1'b1;
            end
            if (reg_wr && reg_addr == OFS_ARG)
                arg_q <= reg_wdata;
            if (reg_wr && reg_addr == OFS_TMO)
                tmo_q <= reg_wdata[TMO_W-1:0];
        end
    end

    sd_cmd_seq #(.TMO_W(TMO_W)) i_seq (
        .clk         (clk),
        .rst         (rst),
        .pending     (cmd_q[CB_START]),
        .combo_bad   (bad_combo(cmd_q)),
        .no_rsp      (cmd_q[CB_NORSP]),
        .busy_wait   (cmd_q[CB_BUSY]),
        .tmo_limit   (tmo_q),
        .rsp_valid   (card_rsp_valid),
        .rsp_crc_err (card_rsp_crc_err),
        .card_busy   (card_busy),
        .req_valid   (card_cmd_valid),
        .rsp_capture (rsp_capture),
        .evt         (evt)
    );

    sd_cmd_rspbank #(.WORDS(RSP_WORDS), .WORD_W(DATA_W)) i_rsp (
        .clk      (clk),
        .rst      (rst),
        .capture  (rsp_capture),
        .long_rsp (cmd_q[CB_LONG]),
        .rsp_data (card_rsp_data),
        .rsp_q    (rsp_q)
    );

    always_comb begin
        sts_set          = '0;
        sts_set[SB_COLL] = collide;
        sts_set[SB_CRC]  = evt.crc;
        sts_set[SB_TMO]  = evt.tmo;
        sts_set[SB_BUSY] = evt.busy_done;
        sts_clr          = (reg_wr && reg_addr == OFS_STS) ? reg_wdata[STS_W-1:0] : '0;
    end

    sd_cmd_status #(.W(STS_W)) i_sts (
        .clk      (clk),
        .rst      (rst),
        .set_bits (sts_set),
        .clr_bits (sts_clr),
        .sts_q    (sts_q)
    );

    assign card_cmd_index = cmd_q[5:0];
    assign card_cmd_arg   = arg_q;
    assign card_cmd_long  = cmd_q[CB_LONG];

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CMD: reg_rdata = {16'd0, cmd_q};
            OFS_ARG: reg_rdata = arg_q;
            OFS_TMO: reg_rdata = DATA_W'(tmo_q);
            OFS_STS: reg_rdata = DATA_W'(sts_q);
            default: reg_rdata = '0;
        endcase
        for (int i = 0; i < RSP_WORDS; i++)
            if (reg_addr == OFS_RSP0 + REG_AW'(4 * i))
                reg_rdata = rsp_q[i];
    end

endmodule

// File: rtl/sd_cmd_engine_chk.sv
module sd_cmd_engine_chk
    import sd_cmd_pkg::*;
(
    input logic                               clk,
    input logic                               rst,
    input logic                               reg_wr,
    input logic [REG_AW-1:0]                  reg_addr,
    input logic                               card_cmd_valid,
    input logic                               card_busy,
    input logic [15:0]                        cmd_q,
    input logic [DATA_W-1:0]                  arg_q,
    input logic [STS_W-1:0]                   sts_q,
    input logic [RSP_WORDS-1:0][DATA_W-1:0]   rsp_q
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (cmd_q == '0 && arg_q == '0 && rsp_q == '0 && sts_q == '0));

    // R2
    req_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        card_cmd_valid |=> !card_cmd_valid);

    // R2
    req_when_pending_chk: assert property (@(posedge clk) disable iff (rst)
        card_cmd_valid |-> cmd_q[CB_START]);

    // R8
    no_req_bad_combo_chk: assert property (@(posedge clk) disable iff (rst)
        card_cmd_valid |-> !(cmd_q[CB_LONG] && cmd_q[CB_BUSY]));

    // R9
    collide_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_CMD && cmd_q[CB_START])
        |=> (sts_q[SB_COLL] && $stable(cmd_q[13:0])));

    // R5
    tmo_sets_fail_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sts_q[SB_TMO]) |-> (cmd_q[CB_FAIL] && !cmd_q[CB_START]));

    // R7
    busy_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sts_q[SB_BUSY]) |-> (cmd_q[CB_BUSY] && !cmd_q[CB_START] && !$past(card_busy)));

endmodule

bind sd_cmd_engine sd_cmd_engine_chk i_chk (
    .clk            (clk),
    .rst            (rst),
    .reg_wr         (reg_wr),
    .reg_addr       (reg_addr),
    .card_cmd_valid (card_cmd_valid),
    .card_busy      (card_busy),
    .cmd_q          (cmd_q),
    .arg_q          (arg_q),
    .sts_q          (sts_q),
    .rsp_q          (rsp_q)
);

// File: tb/test_sd_cmd_engine.sv
module test_sd_cmd_engine;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reg_wr = 1'b0;
    logic [7:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         card_cmd_valid;
    logic [5:0]   card_cmd_index;
    logic [31:0]  card_cmd_arg;
    logic         card_cmd_long;
    logic         card_rsp_valid = 1'b0;
    logic [127:0] card_rsp_data = '0;
    logic         card_rsp_crc_err = 1'b0;
    logic         card_busy = 1'b0;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // responder controls and observations
    bit          r_silent = 1'b0;
    bit          r_crc = 1'b0;
    int          r_delay = 1;
    int          r_busy_len = 0;
    bit          resp_busy = 1'b0;
    int          req_cnt = 0;
    logic [5:0]  seen_idx;
    logic [31:0] seen_arg;
    logic        seen_long;

    logic [31:0] mdl_rsp [4];

    sd_cmd_engine i_sd_cmd_engine (
        .clk              (clk),
        .rst              (rst),
        .reg_wr           (reg_wr),
        .reg_addr         (reg_addr),
        .reg_wdata        (reg_wdata),
        .reg_rdata        (reg_rdata),
        .card_cmd_valid   (card_cmd_valid),
        .card_cmd_index   (card_cmd_index),
        .card_cmd_arg     (card_cmd_arg),
        .card_cmd_long    (card_cmd_long),
        .card_rsp_valid   (card_rsp_valid),
        .card_rsp_data    (card_rsp_data),
        .card_rsp_crc_err (card_rsp_crc_err),
        .card_busy        (card_busy)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [31:0] exp_word(int i, logic [5:0] idx, logic [31:0] arg);
        return (arg ^ (32'h9E37_79B9 * 32'(i + 1))) + {26'd0, idx} + 32'(i);
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    // card stand-in
    initial begin
        forever begin
            @(negedge clk);
            if (card_cmd_valid) begin
                req_cnt++;
                seen_idx  = card_cmd_index;
                seen_arg  = card_cmd_arg;
                seen_long = card_cmd_long;
                if (!r_silent) begin
                    resp_busy = 1'b1;
                    repeat (r_delay) @(negedge clk);
                    for (int i = 0; i < 4; i++)
                        card_rsp_data[i*32 +: 32] = exp_word(i, seen_idx, seen_arg);
                    card_rsp_valid   = 1'b1;
                    card_rsp_crc_err = r_crc;
                    card_busy        = (r_busy_len > 0);
                    @(negedge clk);
                    card_rsp_valid   = 1'b0;
                    card_rsp_crc_err = 1'b0;
                    if (r_busy_len > 1) repeat (r_busy_len - 1) @(negedge clk);
                    card_busy = 1'b0;
                    resp_busy = 1'b0;
                end
            end
        end
    end

    // full command with model-derived expectations
    task automatic do_cmd(logic [5:0] idx, logic [31:0] arg, bit lng, bit norsp, bit bsy,
                          bit rdf, bit wrf, bit silent, bit crc, int dly, int blen, int lim,
                          string tag);
        logic [31:0] v;
        logic [15:0] word;
        int  req0, n;
        bit  lb, tmo, got, e_crc, e_busy, e_fail;
        lb     = lng && bsy;
        tmo    = !lb && !norsp && (silent || (dly - 1 > lim));
        got    = !lb && !norsp && !tmo;
        e_crc  = got && crc;
        e_busy = got && !crc && bsy;
        e_fail = lb || tmo || e_crc;
        word = {4'b0000, bsy, norsp, lng, 1'b0, wrf, rdf, idx};

        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h08, 32'(lim));
        wr(8'h04, arg);
        r_silent = silent || norsp || lb;
        r_crc = crc; r_delay = dly; r_busy_len = blen;
        req0 = req_cnt;
        wr(8'h00, {16'd0, 16'h8000 | word});
        n = 0;
        do begin
            rd(8'h00, v);
            n++;
        end while (v[15] && n < 3000);
        while (resp_busy) @(negedge clk);
        repeat (2) @(negedge clk);

        if (got) begin
            for (int i = 0; i < 4; i++)
                mdl_rsp[i] = (lng || i == 0) ? exp_word(i, idx, arg) : 32'd0;
        end

        rd(8'h00, v);
        check(v[15:0] == ((word & 16'h3FFF) | (16'(e_fail) << 14)),
              {tag, " R4 cmd word after completion"}, v, 32'((word & 16'h3FFF) | (16'(e_fail) << 14)));
        check(req_cnt - req0 == (lb ? 0 : 1), {tag, " R2/R8 request count"},
              32'(req_cnt - req0), lb ? 32'd0 : 32'd1);
        if (!lb)
            check(seen_idx == idx && seen_arg == arg && seen_long == lng,
                  {tag, " R2 request fields"}, {seen_long, seen_idx, 25'd0}, {lng, idx, 25'd0});
        rd(8'h20, v);
        check(v == ((32'(tmo) << 6) | (32'(e_crc) << 4) | (32'(e_busy) << 10)),
              {tag, " R5/R6/R7 status"}, v,
              (32'(tmo) << 6) | (32'(e_crc) << 4) | (32'(e_busy) << 10));
        for (int i = 0; i < 4; i++) begin
            rd(8'(8'h10 + 4 * i), v);
            check(v == mdl_rsp[i], {tag, " R3 response word"}, v, mdl_rsp[i]);
        end
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd1234));
        for (int i = 0; i < 4; i++) mdl_rsp[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd(8'h00, v); check(v == 0, "R1 cmd reset", v, 0);
        rd(8'h04, v); check(v == 0, "R1 arg reset", v, 0);
        rd(8'h20, v); check(v == 0, "R1 status reset", v, 0);
        for (int i = 0; i < 4; i++) begin
            rd(8'(8'h10 + 4 * i), v); check(v == 0, "R1 response reset", v, 0);
        end

        // R2 store without launch
        wr(8'h00, 32'h0000_0011);
        repeat (5) @(negedge clk);
        rd(8'h00, v); check(v == 32'h11, "R2 word stored without start", v, 32'h11);
        check(req_cnt == 0, "R2 no request without start", 32'(req_cnt), 0);

        // directed cases
        do_cmd(6'd17, 32'hCAFE_0001, 0, 0, 0, 1, 0, 0, 0, 3, 0, 20, "short");
        do_cmd(6'd2,  32'h1234_5678, 1, 0, 0, 0, 0, 0, 0, 2, 0, 20, "long");
        do_cmd(6'd0,  32'h0,         0, 1, 0, 0, 0, 0, 0, 1, 0, 20, "norsp R4");
        do_cmd(6'd13, 32'h0BAD_0BAD, 0, 0, 0, 0, 0, 0, 1, 2, 0, 20, "crc R6");
        do_cmd(6'd7,  32'h7777_0007, 0, 0, 1, 0, 1, 0, 0, 2, 6, 20, "busy R7");
        do_cmd(6'd9,  32'h9999_0009, 0, 0, 0, 0, 0, 0, 0, 2, 5, 20, "busy ignored R7");
        do_cmd(6'd25, 32'h2525_2525, 0, 0, 0, 0, 0, 1, 0, 1, 0, 20, "silent R5");
        do_cmd(6'd30, 32'h3030_3030, 0, 0, 0, 0, 0, 0, 0, 6, 0, 5,  "edge ok R5");
        do_cmd(6'd31, 32'h3131_3131, 0, 0, 0, 0, 0, 0, 0, 7, 0, 5,  "edge late R5");
        do_cmd(6'd40, 32'h4040_4040, 1, 0, 1, 0, 0, 0, 0, 1, 0, 20, "combo R8");

        // R9 write while pending
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h08, 32'd200);
        r_silent = 1'b1;
        wr(8'h00, 32'h0000_8005);
        repeat (3) @(negedge clk);
        wr(8'h00, 32'h0000_823F);
        rd(8'h00, v); check(v[13:0] == 14'h0005 && v[15], "R9 ignored write keeps word", v, 32'h8005);
        rd(8'h20, v); check(v[1], "R9 collision status", v, 32'h2);
        do begin rd(8'h00, v); end while (v[15]);
        rd(8'h20, v); check(v == 32'h42, "R5/R9 status after timeout", v, 32'h42);

        // R10 write-one-to-clear
        wr(8'h20, 32'h0);
        rd(8'h20, v); check(v == 32'h42, "R10 zero write keeps bits", v, 32'h42);
        wr(8'h20, 32'h40);
        rd(8'h20, v); check(v == 32'h2, "R10 one clears only that bit", v, 32'h2);
        wr(8'h20, 32'h2);
        rd(8'h20, v); check(v == 32'h0, "R10 all clear", v, 0);

        // constrained random
        for (int k = 0; k < 40; k++) begin
            bit lng, bsy, nr, sil, crc;
            lng = $urandom % 2;
            bsy = ($urandom % 3) == 0;
            if (lng && bsy && ($urandom % 4) != 0) bsy = 1'b0;
            nr  = ($urandom % 6) == 0;
            sil = ($urandom % 8) == 0;
            crc = ($urandom % 6) == 0;
            do_cmd(6'($urandom % 64), $urandom, lng, nr, bsy, 1'($urandom % 2), 1'($urandom % 2),
                   sil, crc, 1 + int'($urandom % 8), int'($urandom % 6), 20, "random R3");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                failures++;
                checks++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, WATCHDOG);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

endmodule